// File: doc/BRIEF.md
# Slot-Based Serial Audio Frame Transmitter

This block is the transmit side of a master serial audio port. One strobe from an external divider moves it one bit clock forward. From that strobe it builds the frame sync, splits each frame into slots, takes audio words from a valid/ready input and shifts them out MSB first on one data line. An output-enable shows when the line is driven. The frame length in bit clocks, the number of slots, the slot width and an enable bit for each slot are all configurable.

A side-mode bit picks how frame sync is used. When the bit is clear, frame sync is a single-bit pulse that marks the start of the frame, as in PCM, DSP or TDM framing. When it is set, the level of frame sync tells the left half-frame from the right half-frame, as in I2S-style and justified framing. The declared slots are then shared equally between the two halves. Bit clocks left over after the last slot of a frame (side-mode clear) or of a half-frame (side-mode set) are filler. A fill bit decides whether filler is driven as zero or left at high impedance.

The controller has two states. In `ST_IDLE` the outputs are quiet and the configuration inputs are copied into internal registers on every clock. The transition IDLE→RUN is taken when `enable` is high. In `ST_RUN` one bit position is presented for each strobe, starting at frame position 0. The transition RUN→IDLE is taken when `enable` is low.

Top module: `tdm_serial_tx`

## Requirements
- R1: The configuration inputs are copied only while the block is in `ST_IDLE`. Changing them in `ST_RUN` has no effect on any output.
- R2: After `enable` rises, the block enters `ST_RUN` on the next clock. The first `bit_tick` after that presents frame position 0. Outputs are registered and change on the clock edge at which `bit_tick` is high.
- R3: With `cfg_side_mode`=0, `fsync` is 1 for position 0 only. One frame is `cfg_frame_len` ticks long.
- R4: With `cfg_side_mode`=1 and frame length L, `fsync` is 0 for positions 0..L/2-1 and 1 for positions L/2..L-1. The first half-frame holds slots 0..N/2-1 and the second half-frame holds slots N/2..N-1. Each half-frame starts its slot timing at its own first position.
- R5: `cfg_slot_size` codes 0, 1, 2 and 3 give 8, 16, 32 and 32 bits per slot. A slot sends the low slot-width bits of its word, MSB first, one bit per tick.
- R6: The enable bit for slot g is `cfg_slot_en[g]`. `s_ready` is high only during the tick at the first bit of an enabled slot. A disabled slot drives 0 with `sd_oe`=1 and takes no word.
- R7: Filler positions drive `sd_out`=0 with `sd_oe`=1 when `cfg_fill_hiz`=0, and drive `sd_oe`=0 when `cfg_fill_hiz`=1.
- R8: If `s_valid` is low at the start of an enabled slot, that slot sends zeros and `underrun` goes to 1. `underrun` stays at 1 until the next transition IDLE→RUN clears it.
- R9: One clock after `enable` falls, the block is in `ST_IDLE` with `sd_out`, `sd_oe`, `fsync` and `s_ready` all 0.
- R10: While in `ST_RUN`, all serial outputs hold their values in cycles without `bit_tick`.
- R11: After reset, `sd_out`, `sd_oe`, `fsync`, `s_ready` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request |
| bit_tick | input | 1 | One-cycle strobe per bit clock |
| cfg_frame_len | input | FRAME_W | Frame length in bit clocks |
| cfg_slot_count | input | CNT_W | Number of declared slots |
| cfg_slot_size | input | 2 | Slot width code |
| cfg_slot_en | input | MAX_SLOTS | Enable bit for each slot |
| cfg_side_mode | input | 1 | 1: frame sync level marks the channel side |
| cfg_fill_hiz | input | 1 | 1: filler positions release the line |
| s_data | input | WORD_W | Audio word, right-aligned |
| s_valid | input | 1 | Word available |
| s_ready | output | 1 | Word taken during this cycle |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data drive enable |
| fsync | output | 1 | Frame sync |
| underrun | output | 1 | Sticky flag: a slot started with no word |

## Verification
The bench runs several configurations for two full frames each, and checks every position against an arithmetic model of the slot map. Frames whose slots fill them exactly are compared with frames that leave filler, and both are run in start-pulse mode and in side mode, with both fill choices. This separates slot-boundary errors from half-frame offset errors and from fill-polarity errors. Slot masks with gaps, all three widths, and upper bits of `s_data` that must be ignored show whether words are fetched at the right slot starts and aligned to the right bit. Strobes spaced by idle cycles, a withheld `s_valid`, and configuration inputs changed at random while running test the hold behaviour, the underrun behaviour and the configuration-copy behaviour.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } stx_state_e;

    // Slot width code to log2(width/8): 8, 16, 32, 32 bits.
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        unique case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/stx_bit_pos.sv
module stx_bit_pos #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [FRAME_W-1:0] frame_len,
    output logic [FRAME_W-1:0] pos
);

    logic [FRAME_W-1:0] last_pos;
    assign last_pos = frame_len - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos >= last_pos) ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/stx_slot_map.sv
module stx_slot_map #(
    parameter int FRAME_W   = 8,
    parameter int MAX_SLOTS = 16,
    parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
    input  logic [FRAME_W-1:0]   pos,
    input  logic [FRAME_W-1:0]   frame_len,
    input  logic [CNT_W-1:0]     slot_count,
    input  logic [1:0]           size_code,
    input  logic [MAX_SLOTS-1:0] slot_en,
    input  logic                 side_mode,
    output logic [1:0]           shamt,
    output logic                 fs_level,
    output logic                 slot_first,
    output logic                 slot_filler,
    output logic                 slot_on
);
    import stx_pkg::*;

    localparam int IDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

    logic [FRAME_W-1:0] half_len;
    logic [FRAME_W-1:0] offset;
    logic [FRAME_W-1:0] slot_in_side;
    logic [FRAME_W-1:0] bit_mask;
    logic [CNT_W-1:0]   side_slots;
    logic [IDX_W-1:0]   slot_idx;
    logic               second_half;

    always_comb begin
        shamt        = width_shift(size_code);
        half_len     = side_mode ? (frame_len >> 1) : frame_len;
        second_half  = side_mode && (pos >= half_len);
        offset       = second_half ? (pos - half_len) : pos;
        slot_in_side = offset >> (3 + shamt);
        bit_mask     = FRAME_W'((32'd8 << shamt) - 32'd1);
        side_slots   = side_mode ? (slot_count >> 1) : slot_count;
        slot_filler  = int'(slot_in_side) >= int'(side_slots);
        slot_idx     = IDX_W'(slot_in_side) + (second_half ? IDX_W'(side_slots) : '0);
        slot_on      = !slot_filler && slot_en[slot_idx];
        slot_first   = (offset & bit_mask) == '0;
        fs_level     = side_mode ? second_half : (pos == '0);
    end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [1:0]        shamt,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);

    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] aligned;

    // Move the slot's MSB to the top of the register.
    assign aligned = word << (WORD_W - (8 << shamt));
    assign bit_out = load ? aligned[WORD_W-1] : sreg[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= aligned << 1;
        end else if (shift_en) begin
            sreg <= sreg << 1;
        end
    end

endmodule

// File: rtl/tdm_serial_tx.sv
module tdm_serial_tx #(
    parameter int FRAME_W   = 8,
    parameter int MAX_SLOTS = 16,
    parameter int WORD_W    = 32,
    parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 bit_tick,
    input  logic [FRAME_W-1:0]   cfg_frame_len,
    input  logic [CNT_W-1:0]     cfg_slot_count,
    input  logic [1:0]           cfg_slot_size,
    input  logic [MAX_SLOTS-1:0] cfg_slot_en,
    input  logic                 cfg_side_mode,
    input  logic                 cfg_fill_hiz,
    input  logic [WORD_W-1:0]    s_data,
    input  logic                 s_valid,
    output logic                 s_ready,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 fsync,
    output logic                 underrun
);
    import stx_pkg::*;

    stx_state_e state_q, state_d;

    logic [FRAME_W-1:0]   len_q;
    logic [CNT_W-1:0]     count_q;
    logic [1:0]           size_q;
    logic [MAX_SLOTS-1:0] en_q;
    logic                 side_q;
    logic                 hiz_q;

    logic [FRAME_W-1:0] pos;
    logic [1:0]         shamt;
    logic               fs_level, slot_first, slot_filler, slot_on;
    logic               run_tick, slot_load, shift_bit;
    logic               nxt_sd, nxt_oe;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_IDLE;
        endcase
    end

    // ---------------- configuration copy (idle only) ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            count_q <= '0;
            size_q  <= '0;
            en_q    <= '0;
            side_q  <= 1'b0;
            hiz_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            len_q   <= cfg_frame_len;
            count_q <= cfg_slot_count;
            size_q  <= cfg_slot_size;
            en_q    <= cfg_slot_en;
            side_q  <= cfg_side_mode;
            hiz_q   <= cfg_fill_hiz;
        end
    end

    assign run_tick  = (state_q == ST_RUN) && enable && bit_tick;
    assign slot_load = run_tick && slot_first && slot_on;
    assign s_ready   = slot_load;

    stx_bit_pos #(.FRAME_W(FRAME_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .step      (run_tick),
        .frame_len (len_q),
        .pos       (pos)
    );

    stx_slot_map #(.FRAME_W(FRAME_W), .MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) u_map (
        .pos         (pos),
        .frame_len   (len_q),
        .slot_count  (count_q),
        .size_code   (size_q),
        .slot_en     (en_q),
        .side_mode   (side_q),
        .shamt       (shamt),
        .fs_level    (fs_level),
        .slot_first  (slot_first),
        .slot_filler (slot_filler),
        .slot_on     (slot_on)
    );

    stx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load),
        .shift_en (run_tick),
        .shamt    (shamt),
        .word     (s_valid ? s_data : '0),
        .bit_out  (shift_bit)
    );

    // ---------------- output process ----------------
    always_comb begin
        nxt_oe = 1'b1;
        nxt_sd = 1'b0;
        if (slot_filler)  nxt_oe = !hiz_q;
        else if (slot_on) nxt_sd = shift_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_out <= 1'b0;
            sd_oe  <= 1'b0;
            fsync  <= 1'b0;
        end else if (state_q == ST_IDLE || !enable) begin
            sd_out <= 1'b0;
            sd_oe  <= 1'b0;
            fsync  <= 1'b0;
        end else if (run_tick) begin
            sd_out <= nxt_sd;
            sd_oe  <= nxt_oe;
            fsync  <= fs_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               underrun <= 1'b0;
        else if (state_q == ST_IDLE && enable)    underrun <= 1'b0;
        else if (slot_load && !s_valid)           underrun <= 1'b1;
    end

    // ---------------- assertions ----------------
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sd_oe && !fsync && !s_ready && !sd_out));

    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && enable && !bit_tick) |=> $stable({sd_out, sd_oe, fsync}));

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(state_q == ST_IDLE && enable)) |=> underrun);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && fsync && !side_q && len_q > 1) |=> !fsync);

    a_r4_first_half_low: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && side_q && pos == '0) |=> !fsync);

    a_r7_float_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

endmodule

// File: tb/tdm_serial_tx_bench.sv
`timescale 1ns/100ps
module tdm_serial_tx_bench;

    localparam int FRAME_W = 8;
    localparam int MAX_SLOTS = 16;
    localparam int WORD_W = 32;
    localparam int CNT_W = $clog2(MAX_SLOTS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic bit_tick = 1'b0;
    logic [FRAME_W-1:0] cfg_frame_len = '0;
    logic [CNT_W-1:0] cfg_slot_count = '0;
    logic [1:0] cfg_slot_size = '0;
    logic [MAX_SLOTS-1:0] cfg_slot_en = '0;
    logic cfg_side_mode = 1'b0;
    logic cfg_fill_hiz = 1'b0;
    logic [WORD_W-1:0] s_data = '0;
    logic s_valid = 1'b0;
    logic s_ready, sd_out, sd_oe, fsync, underrun;

    int nchecks = 0;
    int nerrors = 0;

    always #2 clk = ~clk;

    tdm_serial_tx #(.FRAME_W(FRAME_W), .MAX_SLOTS(MAX_SLOTS), .WORD_W(WORD_W)) u_tdm_serial_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
        .cfg_frame_len(cfg_frame_len), .cfg_slot_count(cfg_slot_count),
        .cfg_slot_size(cfg_slot_size), .cfg_slot_en(cfg_slot_en),
        .cfg_side_mode(cfg_side_mode), .cfg_fill_hiz(cfg_fill_hiz),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .sd_out(sd_out), .sd_oe(sd_oe), .fsync(fsync), .underrun(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] word_of(input int k);
        return 32'hC3A5_1E00 + 32'(k) * 32'h0131_0F1B;
    endfunction

    task automatic run_cfg(input bit mode, input int len, input int n, input int sz,
                           input int en, input bit hiz, input bit vpat, input int gap,
                           input bit scramble);
        int bits, half, side, k, j;
        logic [31:0] cur;
        bit exp_under;
        logic [2:0] held;
        bits = 8 << ((sz >= 2) ? 2 : sz);
        half = mode ? len / 2 : len;
        side = mode ? n / 2 : n;
        k = 0; j = 0; cur = '0; exp_under = 1'b0;

        @(negedge clk);
        cfg_frame_len = FRAME_W'(len); cfg_slot_count = CNT_W'(n);
        cfg_slot_size = 2'(sz); cfg_slot_en = MAX_SLOTS'(en);
        cfg_side_mode = mode; cfg_fill_hiz = hiz;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 underrun cleared on enable", 32'(underrun), 32'd0);

        for (int t = 0; t < 2 * len; t++) begin
            int p, off, sis, bis, g;
            bit sec, fill, on, first, eoe, esd, efs, eready, v;
            p = t % len;
            sec = mode && (p >= half);
            off = sec ? p - half : p;
            sis = off / bits;
            bis = off % bits;
            fill = sis >= side;
            g = sec ? side + sis : sis;
            on = !fill && en[g];
            first = (bis == 0);
            efs = mode ? sec : (p == 0);
            eready = on && first;
            v = vpat ? ((j % 3) != 2) : 1'b1;

            s_valid = v;
            s_data = word_of(k);
            bit_tick = 1'b1;
            if (scramble) begin
                cfg_frame_len = FRAME_W'($urandom);
                cfg_slot_count = CNT_W'($urandom);
                cfg_slot_size = 2'($urandom);
                cfg_slot_en = MAX_SLOTS'($urandom);
                cfg_side_mode = 1'($urandom);
                cfg_fill_hiz = 1'($urandom);
            end
            #1;
            chk("R6 ready at enabled slot start", 32'(s_ready), 32'(eready));
            if (eready) begin
                if (v) begin
                    cur = (bits == 32) ? word_of(k) : (word_of(k) & ((32'd1 << bits) - 1));
                    k++;
                end else begin
                    cur = '0;
                    exp_under = 1'b1;
                end
                j++;
            end
            esd = on ? cur[bits - 1 - bis] : 1'b0;
            eoe = fill ? !hiz : 1'b1;

            @(negedge clk);
            bit_tick = 1'b0;
            if (t == 0) chk("R2 first tick is frame start", {30'd0, fsync, sd_oe}, {30'd0, efs, eoe});
            if (mode) chk("R4 side level", 32'(fsync), 32'(efs));
            else      chk("R3 start pulse", 32'(fsync), 32'(efs));
            if (fill) chk("R7 filler drive", {30'd0, sd_oe, sd_out}, {30'd0, eoe, 1'b0});
            else if (!on) chk("R6 disabled slot zero", {30'd0, sd_oe, sd_out}, {30'd0, 1'b1, 1'b0});
            else if (scramble) chk("R1 config frozen while running", {30'd0, sd_oe, sd_out}, {30'd0, eoe, esd});
            else chk("R5 slot data bit", {30'd0, sd_oe, sd_out}, {30'd0, eoe, esd});

            held = {sd_out, sd_oe, fsync};
            for (int w = 0; w < gap; w++) begin
                @(negedge clk);
                chk("R10 hold without tick", 32'({sd_out, sd_oe, fsync}), 32'(held));
            end
        end

        chk("R8 underrun flag", 32'(underrun), 32'(exp_under));
        enable = 1'b0;
        s_valid = 1'b0;
        @(negedge clk);
        chk("R9 quiet after disable", {28'd0, sd_out, sd_oe, fsync, s_ready}, 32'd0);
        chk("R8 underrun held after disable", 32'(underrun), 32'(exp_under));
    endtask

    initial begin
        #(4 * 150000);
        nerrors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", {27'd0, sd_out, sd_oe, fsync, s_ready, underrun}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 outputs after reset release", {27'd0, sd_out, sd_oe, fsync, s_ready, underrun}, 32'd0);

        // mode, len, slots, size, enables, hiz, valid pattern, gap, scramble
        run_cfg(1'b0, 64, 4, 1, 'hF,  1'b0, 1'b0, 0, 1'b1);
        run_cfg(1'b0, 40, 3, 0, 'h5,  1'b1, 1'b0, 1, 1'b0);
        run_cfg(1'b1, 64, 2, 1, 'h3,  1'b0, 1'b0, 0, 1'b0);
        run_cfg(1'b1, 80, 4, 0, 'hB,  1'b1, 1'b0, 2, 1'b0);
        run_cfg(1'b1, 64, 2, 2, 'h3,  1'b0, 1'b1, 0, 1'b0);
        run_cfg(1'b0, 48, 6, 0, 'h3F, 1'b0, 1'b1, 1, 1'b0);
        run_cfg(1'b0, 96, 3, 3, 'h7,  1'b1, 1'b0, 0, 1'b0);
        run_cfg(1'b1, 72, 6, 0, 'h2D, 1'b0, 1'b0, 1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule